// File: doc/BRIEF.md
# Transmit Frame Sequencer

This block decides the byte-level order of an outgoing framed packet for two rates of a serial infrared link: the slow framed mode and the medium-rate mode. Each frame opens with a number of beginning flags. A 4-bit code sets that number, and the code is decoded differently in each mode. The payload bytes follow, taken one at a time from a valid/ready byte source. Then comes a request to append the frame check sequence, and last an end flag. The result is a tagged symbol stream with valid/ready handshaking. A downstream stage turns the tags into flag octets, CRC bytes and line pulses. CRC arithmetic, escape stuffing and modulation are outside this block.

A frame ends in one of three ways. The first is a 12-bit length countdown: a length register is copied into a current counter, and the counter drops by one for each payload byte. The second is an end marker that the host arms, which makes the next payload byte the last one. The third is a source underrun, when that option is on: the frame is then closed at once with an inverted check sequence. When the enable is dropped, bytes already queued still go out as frames, but the transmit-empty event is not raised.

The controller has five states. IDLE waits for work. FLAG emits beginning flags. BODY passes payload bytes. CHECK emits the check-sequence request. CLOSE emits the end flag. The transitions are:
- start (IDLE→FLAG)
- flags-done (FLAG→BODY)
- last-byte or underrun (BODY→CHECK)
- check-sent (CHECK→CLOSE)
- frame-sent (CLOSE→IDLE)

Top module: `tx_frame_seq`

## Requirements
- R1: While reset is held and just after it, sym_valid, src_ready and tx_empty_evt are 0 and cur_count is 0. The length register resets to 800h.
- R2: In slow mode (mode_med=0), a frame opens with this many BOF symbols for flag_code values 0 to 9: 1, 2, 3, 4, 5, 7, 9, 13, 17, 25. Codes 10 to 15 give 49 flags. The code and the mode are sampled on the start transition.
- R3: In medium mode (mode_med=1), a frame opens with this many BOF symbols for codes 0 to 7: 2, 3, 4, 5, 8, 12, 16, 24. Codes 8 to 15 give 24 flags.
- R4: After the flags, each source byte is passed out as one DATA symbol in order, with sym_data equal to the byte. src_ready is high only in BODY, and then it equals sym_ready.
- R5: A rising tx_en while IDLE copies the length register into cur_count. With len_cnt_en=1, each payload byte taken lowers cur_count by one. The byte that brings it to zero is followed by one CRC symbol and then one EOF symbol.
- R6: cur_count is reloaded from the length register when the last beginning flag of each frame is accepted. A host write (len_wr) changes only the length register and never cur_count.
- R7: A pulse on eot_set makes the next payload byte taken in a later cycle the last byte of its frame. The marker clears once that frame's EOF is accepted. With len_cnt_en=0, only the marker ends a frame, and cur_count holds its value.
- R8: With inv_on_underrun=1, if the source has no byte while in BODY after at least one payload byte, the frame closes at once with CRC_INV and then EOF. With inv_on_underrun=0, the block waits in BODY with sym_valid low.
- R9: While sym_valid is high and sym_ready is low, the symbol is held and no state advances.
- R10: tx_empty_evt pulses for one cycle after an EOF is accepted if tx_en is high and the source is empty at that moment. After tx_en falls, queued bytes still go out as complete frames, and no tx_empty_evt is raised for them.
- R11: The sym_kind codes are BOF=0, DATA=1, CRC=2, CRC_INV=3 and EOF=4. sym_data is 0 for every tag except DATA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; its rising edge loads the counter |
| mode_med | input | 1 | 0 = slow framed mode, 1 = medium-rate mode |
| flag_code | input | 4 | Beginning-flag count code |
| len_cnt_en | input | 1 | Frame end decided by the length countdown |
| inv_on_underrun | input | 1 | Close the frame with an inverted CRC on underrun |
| eot_set | input | 1 | Arms the end marker for the next byte |
| len_wr | input | 1 | Host write strobe for the length register |
| len_wdata | input | 12 | Length value to write |
| src_valid | input | 1 | Source byte available |
| src_data | input | 8 | Source byte |
| src_ready | output | 1 | Source byte taken |
| sym_valid | output | 1 | Symbol valid |
| sym_ready | input | 1 | Downstream accepts the symbol |
| sym_kind | output | 3 | Symbol tag |
| sym_data | output | 8 | Payload byte for DATA symbols |
| cur_count | output | 12 | Current frame-length counter |
| tx_empty_evt | output | 1 | Transmit-empty event pulse |

## Verification
A wrong flag counter shows at the first DATA symbol of a frame, because it arrives a flag early or late. A wrong counter or end marker shows within one symbol of the intended last byte, as an extra or missing DATA symbol ahead of CRC. The scoreboard compares every accepted symbol in order, so the first misplaced tag is reported in the same cycle it is accepted. A wrong reload or host-write path shows in cur_count, which is read while the block is idle. A wrong drain or event decision shows in the tx_empty_evt pulse count around the EOF of the last frame.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

    localparam int FLAG_W = 6;

    typedef enum logic [2:0] {
        SYM_BOF  = 3'd0,
        SYM_DATA = 3'd1,
        SYM_CRC  = 3'd2,
        SYM_CRCX = 3'd3,
        SYM_EOF  = 3'd4
    } sym_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FLAG  = 3'd1,
        ST_BODY  = 3'd2,
        ST_CHECK = 3'd3,
        ST_CLOSE = 3'd4
    } seq_state_e;

    // Number of opening flags for a mode and a 4-bit code.
    function automatic logic [FLAG_W-1:0] flag_count(input logic med, input logic [3:0] code);
        logic [FLAG_W-1:0] n;
        if (!med) begin
            case (code)
                4'd0, 4'd1, 4'd2, 4'd3, 4'd4: n = FLAG_W'(code) + FLAG_W'(1);
                4'd5:    n = FLAG_W'(7);
                4'd6:    n = FLAG_W'(9);
                4'd7:    n = FLAG_W'(13);
                4'd8:    n = FLAG_W'(17);
                4'd9:    n = FLAG_W'(25);
                default: n = FLAG_W'(49);
            endcase
        end else begin
            case (code)
                4'd0, 4'd1, 4'd2, 4'd3: n = FLAG_W'(code) + FLAG_W'(2);
                4'd4:    n = FLAG_W'(8);
                4'd5:    n = FLAG_W'(12);
                4'd6:    n = FLAG_W'(16);
                default: n = FLAG_W'(24);
            endcase
        end
        return n;
    endfunction

endpackage

// File: rtl/tfs_flag_decode.sv
module tfs_flag_decode
    import tfs_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              mode_med,
    input  logic [CODE_W-1:0] code,
    output logic [FLAG_W-1:0] count
);
    always_comb begin
        count = flag_count(mode_med, 4'(code));
    end
endmodule

// File: rtl/tfs_len_counter.sv
module tfs_len_counter #(
    parameter int              LEN_W     = 12,
    parameter logic [LEN_W-1:0] LEN_RESET = 12'h800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_data,
    input  logic             load,
    input  logic             dec,
    output logic [LEN_W-1:0] cur,
    output logic             at_one
);
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= LEN_RESET;
        end else if (wr_en) begin
            len_q <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load) begin
            cur <= len_q;
        end else if (dec) begin
            cur <= cur - LEN_W'(1);
        end
    end

    assign at_one = (cur == LEN_W'(1));
endmodule

// File: rtl/tx_frame_seq.sv
module tx_frame_seq
    import tfs_pkg::*;
#(
    parameter int               LEN_W     = 12,
    parameter logic [LEN_W-1:0] LEN_RESET = 12'h800,
    parameter int               DATA_W    = 8,
    parameter int               CODE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              mode_med,
    input  logic [CODE_W-1:0] flag_code,
    input  logic              len_cnt_en,
    input  logic              inv_on_underrun,
    input  logic              eot_set,
    input  logic              len_wr,
    input  logic [LEN_W-1:0]  len_wdata,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic              sym_valid,
    input  logic              sym_ready,
    output logic [2:0]        sym_kind,
    output logic [DATA_W-1:0] sym_data,
    output logic [LEN_W-1:0]  cur_count,
    output logic              tx_empty_evt
);
    seq_state_e        state_q, state_d;
    logic [FLAG_W-1:0] flags_left_q;
    logic [FLAG_W-1:0] flag_total;
    logic              marker_q, inv_q, seen_q, active_q, tx_en_q;
    logic              cnt_at_one;

    logic sym_take, byte_take, last_byte, underrun, start, flags_done;
    logic load_cur, dec_cur;

    tfs_flag_decode #(.CODE_W(CODE_W)) u_flags (
        .mode_med (mode_med),
        .code     (flag_code),
        .count    (flag_total)
    );

    tfs_len_counter #(.LEN_W(LEN_W), .LEN_RESET(LEN_RESET)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (len_wr),
        .wr_data (len_wdata),
        .load    (load_cur),
        .dec     (dec_cur),
        .cur     (cur_count),
        .at_one  (cnt_at_one)
    );

    // Transition conditions
    assign sym_take   = sym_valid && sym_ready;
    assign byte_take  = (state_q == ST_BODY) && src_valid && sym_ready;
    assign last_byte  = byte_take && (marker_q || (len_cnt_en && cnt_at_one));
    assign underrun   = (state_q == ST_BODY) && !src_valid && seen_q && inv_on_underrun;
    assign start      = (state_q == ST_IDLE) && src_valid && (tx_en || active_q);
    assign flags_done = (state_q == ST_FLAG) && sym_take && (flags_left_q == '0);
    assign load_cur   = (tx_en && !tx_en_q && state_q == ST_IDLE) || flags_done;
    assign dec_cur    = byte_take && len_cnt_en;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start)                  state_d = ST_FLAG;
            ST_FLAG:  if (flags_done)             state_d = ST_BODY;
            ST_BODY:  if (last_byte || underrun)  state_d = ST_CHECK;
            ST_CHECK: if (sym_take)               state_d = ST_CLOSE;
            ST_CLOSE: if (sym_take)               state_d = ST_IDLE;
            default:                              state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sym_valid = 1'b0;
        sym_kind  = SYM_BOF;
        sym_data  = '0;
        src_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FLAG: begin
                sym_valid = 1'b1;
                sym_kind  = SYM_BOF;
            end
            ST_BODY: begin
                sym_valid = src_valid;
                sym_kind  = SYM_DATA;
                sym_data  = src_data;
                src_ready = sym_ready;
            end
            ST_CHECK: begin
                sym_valid = 1'b1;
                sym_kind  = inv_q ? SYM_CRCX : SYM_CRC;
            end
            ST_CLOSE: begin
                sym_valid = 1'b1;
                sym_kind  = SYM_EOF;
            end
            default: ;
        endcase
    end

    // Frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_left_q <= '0;
            marker_q     <= 1'b0;
            inv_q        <= 1'b0;
            seen_q       <= 1'b0;
            active_q     <= 1'b0;
            tx_en_q      <= 1'b0;
            tx_empty_evt <= 1'b0;
        end else begin
            tx_en_q <= tx_en;
            if (tx_en)
                active_q <= 1'b1;
            else if (state_q == ST_IDLE && !src_valid)
                active_q <= 1'b0;

            if (start)
                flags_left_q <= flag_total - FLAG_W'(1);
            else if (state_q == ST_FLAG && sym_take)
                flags_left_q <= flags_left_q - FLAG_W'(1);

            if (start)          seen_q <= 1'b0;
            else if (byte_take) seen_q <= 1'b1;

            if (start)          inv_q <= 1'b0;
            else if (underrun)  inv_q <= 1'b1;

            if (eot_set)
                marker_q <= 1'b1;
            else if (state_q == ST_CLOSE && sym_take)
                marker_q <= 1'b0;

            tx_empty_evt <= (state_q == ST_CLOSE) && sym_take && tx_en && !src_valid;
        end
    end
endmodule

// File: rtl/tfs_seq_checker.sv
module tfs_seq_checker #(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_valid,
    input logic             sym_ready,
    input logic [2:0]       sym_kind,
    input logic             src_valid,
    input logic             src_ready,
    input logic             len_cnt_en,
    input logic [LEN_W-1:0] cur_count,
    input logic             load_cur,
    input logic             tx_en,
    input logic             tx_empty_evt
);
    // R11: only defined tags appear
    p_kind_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sym_valid |-> (sym_kind <= 3'd4));

    // R9: a stalled non-payload symbol is held
    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && !sym_ready && sym_kind != 3'd1) |=> (sym_valid && $stable(sym_kind)));

    // R4: the source is only drained in the payload phase
    p_src_in_body_r4: assert property (@(posedge clk) disable iff (!rst_n)
        src_ready |-> (sym_kind == 3'd1));

    // R5: one decrement per counted payload byte
    p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_ready && len_cnt_en) |=> (cur_count == $past(cur_count) - LEN_W'(1)));

    // R5: a check request is followed by the end flag
    p_check_then_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_ready && (sym_kind == 3'd2 || sym_kind == 3'd3)) |=>
            (sym_valid && sym_kind == 3'd4));

    // R6: without a reload or a counted byte the counter holds, host writes included
    p_count_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_cur && !(src_valid && src_ready && len_cnt_en)) |=> $stable(cur_count));

    // R10: the empty event needs the enable
    p_evt_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_evt |-> $past(tx_en));
endmodule

bind tx_frame_seq tfs_seq_checker #(.LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sym_valid    (sym_valid),
    .sym_ready    (sym_ready),
    .sym_kind     (sym_kind),
    .src_valid    (src_valid),
    .src_ready    (src_ready),
    .len_cnt_en   (len_cnt_en),
    .cur_count    (cur_count),
    .load_cur     (load_cur),
    .tx_en        (tx_en),
    .tx_empty_evt (tx_empty_evt)
);

// File: tb/tb_tx_frame_seq.sv
module tb_tx_frame_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0, mode_med = 1'b0, len_cnt_en = 1'b1;
    logic        inv_on_underrun = 1'b0, eot_set = 1'b0, len_wr = 1'b0;
    logic [3:0]  flag_code = 4'd0;
    logic [11:0] len_wdata = 12'd0;
    logic        src_valid = 1'b0, sym_ready = 1'b1;
    logic [7:0]  src_data = 8'd0;
    logic        src_ready, sym_valid, tx_empty_evt;
    logic [2:0]  sym_kind;
    logic [7:0]  sym_data;
    logic [11:0] cur_count;

    always #10 clk = ~clk;

    tx_frame_seq dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mode_med(mode_med),
        .flag_code(flag_code), .len_cnt_en(len_cnt_en),
        .inv_on_underrun(inv_on_underrun), .eot_set(eot_set),
        .len_wr(len_wr), .len_wdata(len_wdata),
        .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
        .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_kind(sym_kind),
        .sym_data(sym_data), .cur_count(cur_count), .tx_empty_evt(tx_empty_evt)
    );

    localparam logic [2:0] K_BOF = 3'd0, K_DATA = 3'd1, K_CRC = 3'd2, K_CRCX = 3'd3, K_EOF = 3'd4;

    int checks = 0, fails = 0, cyc = 0, evt_count = 0;
    string cur_req = "R4";
    logic [10:0] expq[$];
    logic [7:0]  src_bytes[$];
    logic        src_gate = 1'b1, take = 1'b0, stall_on = 1'b0;
    logic        prev_stall = 1'b0;
    logic [2:0]  prev_kind = 3'd0;
    logic [10:0] exp_item;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int flags_for(input bit med, input int code);
        if (!med) begin
            if (code < 5) return code + 1;
            case (code)
                5: return 7;  6: return 9;  7: return 13;
                8: return 17; 9: return 25;
                default: return 49;
            endcase
        end else begin
            if (code < 4) return code + 2;
            case (code)
                4: return 8; 5: return 12; 6: return 16;
                default: return 24;
            endcase
        end
    endfunction

    // Source model and scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (take) void'(src_bytes.pop_front());
        src_valid = src_gate && (src_bytes.size() > 0);
        src_data  = (src_bytes.size() > 0) ? src_bytes[0] : 8'h00;
        sym_ready = stall_on ? (cyc % 3 != 0) : 1'b1;
        #1;
        take = src_valid && src_ready;
        if (rst_n) begin
            if (prev_stall)
                check(sym_valid && sym_kind == prev_kind, "R9", "stalled tag held", int'(sym_kind), int'(prev_kind));
            prev_stall = sym_valid && !sym_ready && sym_kind != K_DATA;
            prev_kind  = sym_kind;
            if (tx_empty_evt) evt_count++;
            if (sym_valid && sym_ready) begin
                if (expq.size() == 0) begin
                    check(1'b0, cur_req, "unexpected symbol", int'({sym_kind, sym_data}), -1);
                end else begin
                    exp_item = expq.pop_front();
                    check({sym_kind, sym_data} == exp_item, cur_req, "symbol {kind,data}",
                          int'({sym_kind, sym_data}), int'(exp_item));
                end
            end
        end
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_len(input logic [11:0] v);
        @(negedge clk); len_wr = 1'b1; len_wdata = v;
        @(negedge clk); len_wr = 1'b0;
    endtask

    task automatic push_frame(input bit med, input int code, input int nbytes,
                              input logic [2:0] endk, input logic [7:0] base);
        @(negedge clk);
        mode_med = med; flag_code = 4'(code);
        for (int i = 0; i < flags_for(med, code); i++) expq.push_back({K_BOF, 8'h00});
        for (int i = 0; i < nbytes; i++) expq.push_back({K_DATA, 8'(base + i)});
        expq.push_back({endk, 8'h00});
        expq.push_back({K_EOF, 8'h00});
        for (int i = 0; i < nbytes; i++) src_bytes.push_back(8'(base + i));
    endtask

    task automatic drain(input string req);
        int n = 0;
        while ((expq.size() > 0 || src_bytes.size() > 0) && n < 3000) begin
            @(negedge clk); n++;
        end
        check(expq.size() == 0, req, "pending expected symbols", expq.size(), 0);
        cycles(3);
    endtask

    initial begin
        int ev0;
        cycles(3);
        // R1: reset state
        check(sym_valid == 1'b0, "R1", "sym_valid in reset", sym_valid, 0);
        check(src_ready == 1'b0, "R1", "src_ready in reset", src_ready, 0);
        check(cur_count == 12'd0, "R1", "cur_count in reset", cur_count, 0);
        check(tx_empty_evt == 1'b0, "R1", "tx_empty_evt in reset", tx_empty_evt, 0);
        rst_n = 1'b1;
        cycles(2);
        check(sym_valid == 1'b0 && cur_count == 12'd0, "R1", "idle after reset", cur_count, 0);

        // R1: length register reset value seen through the load on tx_en rise
        @(negedge clk); tx_en = 1'b1;
        cycles(2);
        check(cur_count == 12'h800, "R1", "length reset value loaded", cur_count, 12'h800);
        @(negedge clk); tx_en = 1'b0;
        cycles(2);

        // R6: a host write leaves the current counter alone
        write_len(12'd5);
        cycles(2);
        check(cur_count == 12'h800, "R6", "cur_count after host write", cur_count, 12'h800);

        // R5: load on tx_en rise, countdown ends the frame
        @(negedge clk); tx_en = 1'b1;
        cycles(2);
        check(cur_count == 12'd5, "R5", "cur_count loaded on enable", cur_count, 5);
        ev0 = evt_count;
        cur_req = "R5";
        push_frame(1'b0, 0, 5, K_CRC, 8'h10);
        drain("R5");
        check(cur_count == 12'd0, "R5", "cur_count at frame end", cur_count, 0);
        check(evt_count == ev0 + 1, "R10", "empty event after frame", evt_count, ev0 + 1);

        // R2, R3: every flag code in both modes; R6 reload on each frame
        write_len(12'd2);
        for (int med = 0; med < 2; med++) begin
            for (int code = 0; code < 16; code++) begin
                cur_req = med ? "R3" : "R2";
                push_frame(med[0], code, 2, K_CRC, 8'(8'h40 + code));
                drain(cur_req);
            end
        end
        check(cur_count == 12'd0, "R6", "cur_count after reloaded frames", cur_count, 0);

        // R9: downstream stalls
        stall_on = 1'b1;
        cur_req = "R9";
        push_frame(1'b1, 5, 2, K_CRC, 8'hA0);
        drain("R9");
        push_frame(1'b0, 3, 2, K_CRC, 8'hB0);
        drain("R9");
        stall_on = 1'b0;

        // R7, R8: counting off, only the marker ends the frame; no invert means waiting
        write_len(12'd2);
        @(negedge clk); len_cnt_en = 1'b0; mode_med = 1'b0; flag_code = 4'd0;
        cur_req = "R7";
        expq.push_back({K_BOF, 8'h00});
        for (int i = 0; i < 4; i++) expq.push_back({K_DATA, 8'(8'hC0 + i)});
        expq.push_back({K_CRC, 8'h00});
        expq.push_back({K_EOF, 8'h00});
        for (int i = 0; i < 3; i++) src_bytes.push_back(8'(8'hC0 + i));
        while (src_bytes.size() > 0) @(negedge clk);
        cycles(5);
        check(sym_valid == 1'b0, "R8", "waits on empty source without invert", sym_valid, 0);
        check(expq.size() == 3, "R7", "length does not end the frame when off", expq.size(), 3);
        @(negedge clk); eot_set = 1'b1;
        @(negedge clk); eot_set = 1'b0;
        @(negedge clk); src_bytes.push_back(8'hC3);
        drain("R7");
        check(cur_count == 12'd2, "R7", "counter holds with counting off", cur_count, 2);

        // R7: marker cleared, the next frame runs to its full length
        @(negedge clk); len_cnt_en = 1'b1;
        push_frame(1'b0, 0, 2, K_CRC, 8'hD0);
        drain("R7");

        // R8: underrun closes with inverted CRC
        write_len(12'd10);
        @(negedge clk); inv_on_underrun = 1'b1;
        ev0 = evt_count;
        cur_req = "R8";
        push_frame(1'b0, 1, 3, K_CRCX, 8'hE0);
        drain("R8");
        check(evt_count == ev0 + 1, "R10", "empty event after underrun frame", evt_count, ev0 + 1);
        @(negedge clk); inv_on_underrun = 1'b0;

        // R10: tx_en drops with two frames queued
        write_len(12'd2);
        ev0 = evt_count;
        cur_req = "R10";
        push_frame(1'b0, 0, 2, K_CRC, 8'h20);
        push_frame(1'b0, 0, 2, K_CRC, 8'h22);
        cycles(2);
        tx_en = 1'b0;
        drain("R10");
        check(evt_count == ev0, "R10", "no empty event after disable", evt_count, ev0);
        check(sym_valid == 1'b0, "R10", "idle after drain", sym_valid, 0);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule